// File: doc/BRIEF.md
# Block-Write Configuration Receiver

This block is a receive-only two-wire serial slave that loads the configuration bytes of a clock-distribution device. It watches the clock and data lines through a synchronizer and finds start and stop conditions. It answers one fixed 7-bit address, and it signals acceptance of each byte by pulling the data line low through an active-low output enable.

Every accepted frame has the same layout. The address byte comes first, then a command byte whose value is ignored, then a count N, then N data bytes. The data bytes always fill the configuration store upward from byte 0. No byte can be addressed on its own. The store is presented as one flat parallel bus, so the clock logic can read every setting at the same time. The master may stop after any whole byte. Whatever has been written by then stays, and every other byte keeps its old value.

Top module: `cfg_blkwr_slave`

## Requirements
- R1: After reset `sda_oe_n` is 1 and every byte of `cfg_regs` is 0.
- R2: An address byte of 0xD2 (7-bit address 1101001 followed by a 0 direction bit) is acknowledged. Any other address byte is not acknowledged, and no later byte is acknowledged or stored until the next start condition.
- R3: The address 1101001 with the direction bit set (byte 0xD3, a read) is not acknowledged.
- R4: The byte after an accepted address is acknowledged whatever its value, and it does not change where data bytes are stored.
- R5: A count byte N from 1 to 32 is acknowledged. The next N data bytes are each acknowledged and stored in order into bytes 0 to N-1. Byte k appears on `cfg_regs[8k+7:8k]`.
- R6: A count byte of 0 or above 32 is not acknowledged, and no later byte is acknowledged or stored until the next start condition.
- R7: Data bytes beyond the declared count are not acknowledged and are not stored.
- R8: A stop condition after any complete byte ends the frame. Bytes written in that frame keep their new values, and all other bytes are unchanged.
- R9: A repeated start begins address matching again, and the new frame fills from byte 0.
- R10: For an acknowledged byte, `sda_oe_n` goes to 0 after the SCL falling edge that ends the eighth bit, and returns to 1 after the next SCL falling edge. The signal never changes except after a synchronized SCL falling edge.
- R11: SDA transitions while SCL is low are treated as data and are never taken as a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND) |
| sda_oe_n | output | 1 | Active-low enable that pulls the data line low for an acknowledge |
| cfg_regs | output | MAX_COUNT*8 | Configuration store, byte k at bits 8k+7 down to 8k |

## Verification
The assertions are evaluated on every cycle. They check the following:
- The acknowledge enable changes only after a synchronized SCL falling edge.
- The enable stays released while the frame parser is idle, and is released right after any start.
- The write pointer only steps up by one or returns to zero, and never passes the store size.

The checks that need a whole frame are left to the bench scenarios. These are whether each byte is acknowledged or not, the value and position of every stored byte, the handling of illegal counts and surplus bytes, recovery after a repeated start, and immunity to SDA glitches while SCL is low. The bench sweeps every legal count from 1 to 32 and compares the full store after each frame.

// File: rtl/cfg_blkwr_pkg.sv
package cfg_blkwr_pkg;

    // Position of the frame parser within one transaction.
    typedef enum logic [2:0] {
        FR_IDLE,
        FR_ADDR,
        FR_CMD,
        FR_COUNT,
        FR_DATA
    } frame_st_e;

    // Synchronized line state and the events derived from it.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_evt_t;

    // One received byte, valid for a single cycle.
    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_evt_t;

    // Address byte that carries a write request to the given address.
    function automatic logic [7:0] write_addr_byte(input logic [6:0] a);
        return {a, 1'b0};
    endfunction

    // A count is legal when it is nonzero and no larger than the store.
    function automatic logic count_ok(input logic [7:0] c, input int unsigned lim);
        return (c != 8'd0) && ({24'd0, c} <= lim);
    endfunction

endpackage

// File: rtl/bw_line_sync.sv
module bw_line_sync
    import cfg_blkwr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt_o
);

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign raw = {sda_i, scl_i};

    // Index 0 carries SCL and index 1 carries SDA. Both lines reset to the idle-high level.
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign cur[g] = chain[STAGES-1];
        assign prv[g] = last;
    end

    always_comb begin
        evt_o.scl_rise = cur[0] & ~prv[0];
        evt_o.scl_fall = ~cur[0] & prv[0];
        evt_o.start    = cur[0] & prv[0] & prv[1] & ~cur[1];
        evt_o.stop     = cur[0] & prv[0] & ~prv[1] & cur[1];
        evt_o.sda      = cur[1];
    end

endmodule

// File: rtl/bw_bit_engine.sv
module bw_bit_engine
    import cfg_blkwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt_i,
    input  logic      ack_go_i,
    output byte_evt_t byte_o,
    output logic      sda_oe_n
);

    logic       active;
    logic       in_ack;
    logic       ack_q;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       take_bit;
    logic       byte_done;

    assign take_bit  = active & evt_i.scl_rise & ~in_ack & (bit_cnt < 4'd8);
    assign byte_done = take_bit & (bit_cnt == 4'd7);

    always_comb begin
        byte_o.valid = byte_done;
        byte_o.data  = {shreg[6:0], evt_i.sda};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            in_ack   <= 1'b0;
            ack_q    <= 1'b0;
            bit_cnt  <= 4'd0;
            shreg    <= 8'd0;
            sda_oe_n <= 1'b1;
        end else if (evt_i.start) begin
            active   <= 1'b1;
            in_ack   <= 1'b0;
            bit_cnt  <= 4'd0;
            sda_oe_n <= 1'b1;
        end else if (evt_i.stop) begin
            active   <= 1'b0;
            in_ack   <= 1'b0;
            bit_cnt  <= 4'd0;
            sda_oe_n <= 1'b1;
        end else if (active) begin
            if (take_bit) begin
                shreg   <= {shreg[6:0], evt_i.sda};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (byte_done) begin
                ack_q <= ack_go_i;
            end
            if (evt_i.scl_fall) begin
                if (in_ack) begin
                    in_ack   <= 1'b0;
                    bit_cnt  <= 4'd0;
                    sda_oe_n <= 1'b1;
                    if (!ack_q) begin
                        active <= 1'b0;
                    end
                end else if (bit_cnt == 4'd8) begin
                    in_ack   <= 1'b1;
                    sda_oe_n <= ~ack_q;
                end
            end
        end
    end

endmodule

// File: rtl/bw_frame_ctrl.sv
module bw_frame_ctrl
    import cfg_blkwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'b1101001,
    parameter int          MAX_COUNT = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start_i,
    input  logic                             stop_i,
    input  byte_evt_t                        byte_i,
    output logic                             ack_go_o,
    output logic [MAX_COUNT*8-1:0]           regs_o,
    output logic                             idle_o,
    output logic [$clog2(MAX_COUNT+1)-1:0]   wr_ptr_o
);

    localparam int PTR_W = $clog2(MAX_COUNT + 1);

    frame_st_e          state;
    frame_st_e          nxt;
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   remain;
    logic               cnt_load;
    logic               wr_en;
    logic               wr_fire;

    always_comb begin
        nxt      = state;
        ack_go_o = 1'b0;
        cnt_load = 1'b0;
        wr_en    = 1'b0;
        unique case (state)
            FR_ADDR: begin
                if (byte_i.data == write_addr_byte(DEV_ADDR)) begin
                    ack_go_o = 1'b1;
                    nxt      = FR_CMD;
                end else begin
                    nxt = FR_IDLE;
                end
            end
            FR_CMD: begin
                ack_go_o = 1'b1;
                nxt      = FR_COUNT;
            end
            FR_COUNT: begin
                if (count_ok(byte_i.data, MAX_COUNT)) begin
                    ack_go_o = 1'b1;
                    cnt_load = 1'b1;
                    nxt      = FR_DATA;
                end else begin
                    nxt = FR_IDLE;
                end
            end
            FR_DATA: begin
                if ((remain != '0) && (wr_ptr < PTR_W'(MAX_COUNT))) begin
                    ack_go_o = 1'b1;
                    wr_en    = 1'b1;
                end else begin
                    nxt = FR_IDLE;
                end
            end
            default: begin
                nxt = FR_IDLE;
            end
        endcase
    end

    assign wr_fire = byte_i.valid & wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FR_IDLE;
            wr_ptr <= '0;
            remain <= '0;
        end else if (start_i) begin
            state <= FR_ADDR;
        end else if (stop_i) begin
            state <= FR_IDLE;
        end else if (byte_i.valid) begin
            state <= nxt;
            if (cnt_load) begin
                wr_ptr <= '0;
                remain <= PTR_W'(byte_i.data);
            end
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
                remain <= remain - 1'b1;
            end
        end
    end

    // One holding register per configuration byte, loaded only when the pointer selects it.
    for (genvar g = 0; g < MAX_COUNT; g++) begin : g_store
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 8'd0;
            end else if (wr_fire && (wr_ptr == PTR_W'(g))) begin
                q <= byte_i.data;
            end
        end

        assign regs_o[g*8 +: 8] = q;
    end

    assign idle_o   = (state == FR_IDLE);
    assign wr_ptr_o = wr_ptr;

endmodule

// File: rtl/cfg_blkwr_slave.sv
module cfg_blkwr_slave
    import cfg_blkwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101001,
    parameter int          MAX_COUNT   = 32,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_n,
    output logic [MAX_COUNT*8-1:0] cfg_regs
);

    localparam int PTR_W = $clog2(MAX_COUNT + 1);

    line_evt_t        evt;
    byte_evt_t        rx_byte;
    logic             ack_go;
    logic             in_idle;
    logic [PTR_W-1:0] wr_ptr;

    bw_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    bw_bit_engine u_bits (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .ack_go_i (ack_go),
        .byte_o   (rx_byte),
        .sda_oe_n (sda_oe_n)
    );

    bw_frame_ctrl #(
        .DEV_ADDR  (DEV_ADDR),
        .MAX_COUNT (MAX_COUNT)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .start_i  (evt.start),
        .stop_i   (evt.stop),
        .byte_i   (rx_byte),
        .ack_go_o (ack_go),
        .regs_o   (cfg_regs),
        .idle_o   (in_idle),
        .wr_ptr_o (wr_ptr)
    );

endmodule

// File: rtl/cfg_blkwr_checker.sv
module cfg_blkwr_checker #(
    parameter int MAX_COUNT = 32
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           sda_oe_n,
    input logic                           scl_fall,
    input logic                           start_det,
    input logic                           in_idle,
    input logic [$clog2(MAX_COUNT+1)-1:0] wr_ptr
);

    localparam int PTR_W = $clog2(MAX_COUNT + 1);

    // R10: the acknowledge enable moves only after a synchronized SCL falling edge
    p_oe_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_n) |-> $past(scl_fall));

    // R6: while the parser is idle (rejected or finished frame) the line is never pulled
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        in_idle |-> sda_oe_n);

    // R9: any start, including a repeated one, leaves the line released
    p_start_release_r9: assert property (@(posedge clk) disable iff (rst)
        start_det |=> sda_oe_n);

    // R5: the write pointer stays within the store
    p_ptr_bound_r5: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= PTR_W'(MAX_COUNT));

    // R5: sequential filling means the pointer only steps by one or restarts at zero
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_ptr) |-> ((wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)) || (wr_ptr == '0)));

endmodule

bind cfg_blkwr_slave cfg_blkwr_checker #(
    .MAX_COUNT (MAX_COUNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe_n  (sda_oe_n),
    .scl_fall  (evt.scl_fall),
    .start_det (evt.start),
    .in_idle   (in_idle),
    .wr_ptr    (wr_ptr)
);

// File: tb/cfg_blkwr_slave_bench.sv
module cfg_blkwr_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int NREG       = 32;
    localparam int WDOG       = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe_n;
    logic sda_line;
    logic [NREG*8-1:0] cfg_regs;

    logic [7:0] exp_regs [NREG];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign sda_line = m_sda & sda_oe_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_blkwr_slave u_cfg_blkwr_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe_n (sda_oe_n),
        .cfg_regs (cfg_regs)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [7:0] dval(input int n, input int i);
        return 8'(n * 37 + i * 11 + 5);
    endfunction

    task automatic bus_start();
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_restart();
        m_sda = 1'b1;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        m_sda = 1'b1;
        tick(2 * Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        if (glitch) begin
            m_sda = ~b;
            tick(1);
            m_sda = b;
            tick(1);
            m_sda = ~b;
            tick(1);
        end
        m_sda = b;
        tick(Q);
        m_scl = 1'b1;
        tick(2 * Q);
        m_scl = 1'b0;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], glitch);
        end
        m_sda = 1'b1;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        ack = !sda_line;
        tick(Q);
        m_scl = 1'b0;
        tick(Q);
        // R10: released again once SCL has fallen at the end of the acknowledge slot
        check("R10", 32'(sda_oe_n), 32'd1);
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) begin
            check(tag, 32'(cfg_regs[i*8 +: 8]), 32'(exp_regs[i]));
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        bit a;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'd0;

        tick(5);
        rst = 1'b0;
        tick(3);
        // R1: reset state
        check("R1", 32'(sda_oe_n), 32'd1);
        check_regs("R1");

        // R5 and R4: every legal count, with a different command byte each time
        for (int n = 1; n <= NREG; n++) begin
            bus_start();
            send_byte(8'hD2, 1'b0, a);
            check("R2", 32'(a), 32'd1);
            send_byte(8'(n * 3), 1'b0, a);
            check("R4", 32'(a), 32'd1);
            send_byte(8'(n), 1'b0, a);
            check("R5", 32'(a), 32'd1);
            for (int i = 0; i < n; i++) begin
                d = dval(n, i);
                send_byte(d, 1'b0, a);
                check("R5", 32'(a), 32'd1);
                exp_regs[i] = d;
            end
            bus_stop();
            check_regs("R5");
        end

        // R6: illegal counts are refused and the frame is dead until a new start
        foreach (exp_regs[k]) begin
            if (k < 3) begin
                logic [7:0] bad;
                bad = (k == 0) ? 8'd0 : ((k == 1) ? 8'd33 : 8'hFF);
                bus_start();
                send_byte(8'hD2, 1'b0, a);
                check("R6", 32'(a), 32'd1);
                send_byte(8'h00, 1'b0, a);
                check("R6", 32'(a), 32'd1);
                send_byte(bad, 1'b0, a);
                check("R6", 32'(a), 32'd0);
                send_byte(8'hAA, 1'b0, a);
                check("R6", 32'(a), 32'd0);
                bus_stop();
                check_regs("R6");
            end
        end

        // R7: bytes past the count are refused and discarded
        bus_start();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'd3, 1'b0, a);
        check("R7", 32'(a), 32'd1);
        for (int i = 0; i < 3; i++) begin
            d = 8'hC0 + 8'(i);
            send_byte(d, 1'b0, a);
            check("R7", 32'(a), 32'd1);
            exp_regs[i] = d;
        end
        send_byte(8'h77, 1'b0, a);
        check("R7", 32'(a), 32'd0);
        send_byte(8'h78, 1'b0, a);
        check("R7", 32'(a), 32'd0);
        bus_stop();
        check_regs("R7");

        // R8: stop part way through a declared block
        bus_start();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'd10, 1'b0, a);
        for (int i = 0; i < 4; i++) begin
            d = 8'h90 + 8'(i);
            send_byte(d, 1'b0, a);
            check("R8", 32'(a), 32'd1);
            exp_regs[i] = d;
        end
        bus_stop();
        check_regs("R8");

        // R2: foreign addresses are refused along with everything after them
        for (int k = 0; k < 3; k++) begin
            d = (k == 0) ? 8'hD0 : ((k == 1) ? 8'h52 : 8'hD6);
            bus_start();
            send_byte(d, 1'b0, a);
            check("R2", 32'(a), 32'd0);
            send_byte(8'h00, 1'b0, a);
            check("R2", 32'(a), 32'd0);
            send_byte(8'h01, 1'b0, a);
            check("R2", 32'(a), 32'd0);
            send_byte(8'h5A, 1'b0, a);
            check("R2", 32'(a), 32'd0);
            bus_stop();
            check_regs("R2");
        end

        // R3: read direction is refused
        bus_start();
        send_byte(8'hD3, 1'b0, a);
        check("R3", 32'(a), 32'd0);
        send_byte(8'h00, 1'b0, a);
        check("R3", 32'(a), 32'd0);
        bus_stop();
        check_regs("R3");

        // R9: repeated start inside an accepted frame
        bus_start();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'd5, 1'b0, a);
        send_byte(8'h11, 1'b0, a);
        send_byte(8'h22, 1'b0, a);
        exp_regs[0] = 8'h11;
        exp_regs[1] = 8'h22;
        bus_restart();
        send_byte(8'hD2, 1'b0, a);
        check("R9", 32'(a), 32'd1);
        send_byte(8'h42, 1'b0, a);
        send_byte(8'd2, 1'b0, a);
        check("R9", 32'(a), 32'd1);
        send_byte(8'h33, 1'b0, a);
        check("R9", 32'(a), 32'd1);
        send_byte(8'h44, 1'b0, a);
        check("R9", 32'(a), 32'd1);
        exp_regs[0] = 8'h33;
        exp_regs[1] = 8'h44;
        bus_stop();
        check_regs("R9");

        // R9: repeated start after a refused address
        bus_start();
        send_byte(8'hD0, 1'b0, a);
        check("R9", 32'(a), 32'd0);
        bus_restart();
        send_byte(8'hD2, 1'b0, a);
        check("R9", 32'(a), 32'd1);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'd1, 1'b0, a);
        send_byte(8'h5C, 1'b0, a);
        check("R9", 32'(a), 32'd1);
        exp_regs[0] = 8'h5C;
        bus_stop();
        check_regs("R9");

        // R11: SDA chatter while SCL is low must not look like start or stop
        bus_start();
        send_byte(8'hD2, 1'b1, a);
        check("R11", 32'(a), 32'd1);
        send_byte(8'h00, 1'b1, a);
        check("R11", 32'(a), 32'd1);
        send_byte(8'd4, 1'b1, a);
        check("R11", 32'(a), 32'd1);
        for (int i = 0; i < 4; i++) begin
            d = 8'hA5 ^ 8'(i * 29);
            send_byte(d, 1'b1, a);
            check("R11", 32'(a), 32'd1);
            exp_regs[i] = d;
        end
        bus_stop();
        check_regs("R11");

        finish_run();
    end

endmodule